// File: doc/BRIEF.md
# ADC Command Queue Sequencer

This block runs a list of conversion commands for an analog-to-digital converter. A trigger starts the list at entry 0. The sequencer reads each 16-bit command word from an external table through a combinational read port. It decodes the word into four things: an analog source, a channel, a sample-window length and an amplifier-bypass flag. It then hands these to the converter with a one-cycle start pulse and waits for a done pulse that carries a 10-bit result. The result goes out through a write port at the index of the command that produced it.

A command may set a pause flag. After that conversion the sequencer stops and waits for another trigger, which resumes at the next entry. This lets one table hold several sub-queues. Channel code 63 ends the list without a conversion. Some channel codes are replaced by reference sources. Reaching the last table entry also ends the list. The status outputs tell the surrounding logic whether the sequencer is idle, active, paused or complete.

Top module: `adc_cmd_sequencer`

## Requirements
- R1: Command word fields are: bit 9 = pause, bit 8 = bypass, bits 7:6 = sample-time code, bits 5:0 = channel. Bits 15:10 have no effect on any output. `conv_chan` equals bits 5:0 while `conv_start` is high.
- R2: A trigger sampled while idle or complete starts the queue at index 0. Entries are issued in increasing index order on `cmd_addr`. Each conversion is announced by a `conv_start` pulse that lasts exactly one cycle, and the status is active during it.
- R3: `conv_sample_cyc` is 2, 4, 8 or 16 for the sample-time codes 0, 1, 2 and 3.
- R4: Channels 60, 61 and 62 give `conv_src` 1 (low reference), 2 (high reference) and 3 (midpoint). For these channels `conv_bypass` is forced to 1. For all other channels `conv_bypass` equals bit 8.
- R5: Channels 32 to 47 give `conv_src` 1 (low reference). Channels 0 to 3 and 48 to 59 give `conv_src` 0 (pin).
- R6: Channels 4 to 31 give `conv_src` 0 when `mux_mode` is 1 and `conv_src` 1 when `mux_mode` is 0.
- R7: In the cycle where `conv_done` is sampled, `res_we` is high, `res_addr` equals the index of the command being converted and `res_data` equals `conv_result`.
- R8: After the conversion of a word with the pause bit set, the sequencer is paused and issues nothing until a trigger. That trigger resumes at the next index.
- R9: A word with channel 63 produces no conversion, and the sequencer becomes complete.
- R10: Once entry 63 (the last index) has been converted, the sequencer is complete, whatever its pause bit.
- R11: A trigger sampled while a conversion is outstanding has no effect on the queue.
- R12: Exactly one of `st_idle`, `st_active`, `st_paused`, `st_complete` is high at any time. After reset the sequencer is idle with `cmd_addr` at 0 and no start or write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mux_mode | input | 1 | 1: channels 4 to 31 are pins; 0: they read the low reference |
| trigger | input | 1 | Start or resume pulse |
| cmd_addr | output | 6 | Index of the current command word |
| cmd_data | input | 16 | Command word at `cmd_addr`, combinational |
| conv_start | output | 1 | One-cycle conversion request |
| conv_src | output | 2 | 0 pin, 1 low ref, 2 high ref, 3 midpoint |
| conv_chan | output | 6 | Channel number |
| conv_sample_cyc | output | 5 | Sample window in converter clock periods |
| conv_bypass | output | 1 | Amplifier bypass for this conversion |
| conv_done | input | 1 | Conversion finished |
| conv_result | input | 10 | Converted value, valid with `conv_done` |
| res_we | output | 1 | Result write strobe |
| res_addr | output | 6 | Result index |
| res_data | output | 10 | Result value |
| st_idle | output | 1 | Idle since reset |
| st_active | output | 1 | Issuing or waiting on a conversion |
| st_paused | output | 1 | Stopped at a pause point |
| st_complete | output | 1 | Queue finished |

## Verification
The hardest situation to reach is the end of the table with no end marker. All 64 entries must avoid channel 63, and the run must still pass through pause points, including a pause set on the very last entry. The bench builds tables for this case directly, with the reserved bits filled randomly. It mixes those tables with random tables in which markers and pauses are rare, and it injects triggers while a conversion is outstanding to confirm they are ignored.

// File: rtl/adcq_pkg.sv
package adcq_pkg;
  localparam int CMD_W = 16;
  localparam int CH_W  = 6;
  localparam int CYC_W = 5;

  typedef enum logic [1:0] {
    SRC_PIN  = 2'd0,
    SRC_LOW  = 2'd1,
    SRC_HIGH = 2'd2,
    SRC_MID  = 2'd3
  } src_e;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_ISSUE = 3'd1,
    S_WAIT  = 3'd2,
    S_PAUSE = 3'd3,
    S_DONE  = 3'd4
  } seq_state_e;

  localparam logic [CH_W-1:0] CH_END    = 6'd63;
  localparam logic [CH_W-1:0] CH_VLOW   = 6'd60;
  localparam logic [CH_W-1:0] CH_VHIGH  = 6'd61;
  localparam logic [CH_W-1:0] CH_VMID   = 6'd62;
  localparam logic [CH_W-1:0] CH_RSV_LO = 6'd32;
  localparam logic [CH_W-1:0] CH_RSV_HI = 6'd47;
  localparam logic [CH_W-1:0] CH_MUX_LO = 6'd4;
  localparam logic [CH_W-1:0] CH_MUX_HI = 6'd31;
endpackage

// File: rtl/adcq_cmd_decode.sv
module adcq_cmd_decode
  import adcq_pkg::*;
(
  input  logic [CMD_W-1:0] cmd,
  input  logic             mux_mode,
  output logic [CH_W-1:0]  chan,
  output src_e             src,
  output logic [CYC_W-1:0] sample_cyc,
  output logic             bypass,
  output logic             pause,
  output logic             is_end
);
  logic internal_ch;

  always_comb begin
    chan        = cmd[5:0];
    pause       = cmd[9];
    is_end      = (chan == CH_END);
    internal_ch = (chan == CH_VLOW) || (chan == CH_VHIGH) || (chan == CH_VMID);

    unique case (cmd[7:6])
      2'd0:    sample_cyc = CYC_W'(2);
      2'd1:    sample_cyc = CYC_W'(4);
      2'd2:    sample_cyc = CYC_W'(8);
      default: sample_cyc = CYC_W'(16);
    endcase

    if (chan == CH_VLOW)                                  src = SRC_LOW;
    else if (chan == CH_VHIGH)                            src = SRC_HIGH;
    else if (chan == CH_VMID)                             src = SRC_MID;
    else if (chan >= CH_RSV_LO && chan <= CH_RSV_HI)      src = SRC_LOW;
    else if (!mux_mode && chan >= CH_MUX_LO && chan <= CH_MUX_HI) src = SRC_LOW;
    else                                                  src = SRC_PIN;

    // the sample amplifier is unused for internal sources
    bypass = cmd[8] | internal_ch;
  end
endmodule

// File: rtl/adcq_seq_ctrl.sv
module adcq_seq_ctrl
  import adcq_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trigger,
  input  logic             cmd_pause,
  input  logic             cmd_end,
  input  logic             conv_done,
  output seq_state_e       state,
  output logic [IDX_W-1:0] ptr,
  output logic             conv_start,
  output logic             res_we
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic             pause_q, pause_d;
  logic             ptr_en, pause_en;

  always_comb begin
    state_d    = state_q;
    ptr_d      = ptr_q;
    pause_d    = pause_q;
    ptr_en     = 1'b0;
    pause_en   = 1'b0;
    conv_start = 1'b0;
    res_we     = 1'b0;
    unique case (state_q)
      S_IDLE, S_DONE: begin
        if (trigger) begin
          state_d = S_ISSUE;
          ptr_d   = '0;
          ptr_en  = 1'b1;
        end
      end
      S_ISSUE: begin
        if (cmd_end) begin
          state_d = S_DONE;
        end else begin
          conv_start = 1'b1;
          pause_d    = cmd_pause;
          pause_en   = 1'b1;
          state_d    = S_WAIT;
        end
      end
      S_WAIT: begin
        if (conv_done) begin
          res_we = 1'b1;
          if (ptr_q == LAST) begin
            state_d = S_DONE;
          end else begin
            ptr_d   = ptr_q + 1'b1;
            ptr_en  = 1'b1;
            state_d = pause_q ? S_PAUSE : S_ISSUE;
          end
        end
      end
      S_PAUSE: begin
        if (trigger) state_d = S_ISSUE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      ptr_q   <= '0;
      pause_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (ptr_en)   ptr_q   <= ptr_d;
      if (pause_en) pause_q <= pause_d;
    end
  end

  assign state = state_q;
  assign ptr   = ptr_q;
endmodule

// File: rtl/adc_cmd_sequencer.sv
module adc_cmd_sequencer
  import adcq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int RES_W = 10,
  localparam int IDX_W = $clog2(DEPTH)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mux_mode,
  input  logic             trigger,
  output logic [IDX_W-1:0] cmd_addr,
  input  logic [CMD_W-1:0] cmd_data,
  output logic             conv_start,
  output logic [1:0]       conv_src,
  output logic [CH_W-1:0]  conv_chan,
  output logic [CYC_W-1:0] conv_sample_cyc,
  output logic             conv_bypass,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_result,
  output logic             res_we,
  output logic [IDX_W-1:0] res_addr,
  output logic [RES_W-1:0] res_data,
  output logic             st_idle,
  output logic             st_active,
  output logic             st_paused,
  output logic             st_complete
);
  src_e             dec_src;
  logic             dec_pause, dec_end;
  seq_state_e       state;
  logic [IDX_W-1:0] ptr;

  adcq_cmd_decode u_dec (
    .cmd        (cmd_data),
    .mux_mode   (mux_mode),
    .chan       (conv_chan),
    .src        (dec_src),
    .sample_cyc (conv_sample_cyc),
    .bypass     (conv_bypass),
    .pause      (dec_pause),
    .is_end     (dec_end)
  );

  adcq_seq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .trigger    (trigger),
    .cmd_pause  (dec_pause),
    .cmd_end    (dec_end),
    .conv_done  (conv_done),
    .state      (state),
    .ptr        (ptr),
    .conv_start (conv_start),
    .res_we     (res_we)
  );

  assign conv_src    = dec_src;
  assign cmd_addr    = ptr;
  assign res_addr    = ptr;
  assign res_data    = conv_result;
  assign st_idle     = (state == S_IDLE);
  assign st_active   = (state == S_ISSUE) || (state == S_WAIT);
  assign st_paused   = (state == S_PAUSE);
  assign st_complete = (state == S_DONE);
endmodule

// File: rtl/adcq_seq_checker.sv
module adcq_seq_checker #(
  parameter int IDX_W = 6,
  parameter int RES_W = 10
)(
  input logic             clk,
  input logic             rst_n,
  input logic             mux_mode,
  input logic             trigger,
  input logic [IDX_W-1:0] cmd_addr,
  input logic [15:0]      cmd_data,
  input logic             conv_start,
  input logic [1:0]       conv_src,
  input logic [5:0]       conv_chan,
  input logic [4:0]       conv_sample_cyc,
  input logic             conv_bypass,
  input logic             conv_done,
  input logic [RES_W-1:0] conv_result,
  input logic             res_we,
  input logic [IDX_W-1:0] res_addr,
  input logic [RES_W-1:0] res_data,
  input logic             st_idle,
  input logic             st_active,
  input logic             st_paused,
  input logic             st_complete
);
  p_status_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({st_idle, st_active, st_paused, st_complete}));

  p_start_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  p_start_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> st_active);

  p_sample_pow2_r3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> ($onehot(conv_sample_cyc) && !conv_sample_cyc[0]));

  p_internal_bypass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && conv_chan >= 6'd60 && conv_chan <= 6'd62) |-> (conv_bypass && conv_src != 2'd0));

  p_reserved_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && conv_chan >= 6'd32 && conv_chan <= 6'd47) |-> (conv_src == 2'd1));

  p_write_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |-> (st_active && !conv_start));

  p_pause_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_paused && !trigger) |=> st_paused);

  p_no_start_on_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> (conv_chan != 6'd63));

  p_wait_ignores_trigger_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(conv_start) && !conv_done) |=> (st_active && $stable(cmd_addr)));
endmodule

bind adc_cmd_sequencer adcq_seq_checker #(.IDX_W(IDX_W), .RES_W(RES_W)) chk_i (.*);

// File: tb/adc_cmd_sequencer_tb_top.sv
module adc_cmd_sequencer_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, mux_mode, trigger, conv_done;
  logic [5:0]  cmd_addr, res_addr, conv_chan;
  logic [15:0] cmd_data;
  logic        conv_start, conv_bypass, res_we;
  logic [1:0]  conv_src;
  logic [4:0]  conv_sample_cyc;
  logic [9:0]  conv_result, res_data;
  logic        st_idle, st_active, st_paused, st_complete;

  logic [15:0] tbl [64];
  assign cmd_data = tbl[cmd_addr];

  int errs = 0;
  int checks = 0;

  adc_cmd_sequencer dut_i (.*);

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_src(input logic [15:0] c, input bit mux);
    int ch = int'(c[5:0]);
    if (ch == 60) return 1;
    if (ch == 61) return 2;
    if (ch == 62) return 3;
    if (ch >= 32 && ch <= 47) return 1;
    if (!mux && ch >= 4 && ch <= 31) return 1;
    return 0;
  endfunction

  function automatic int exp_cyc(input logic [15:0] c);
    return 2 << c[7:6];
  endfunction

  function automatic int exp_byp(input logic [15:0] c);
    int ch = int'(c[5:0]);
    return (c[8] || (ch >= 60 && ch <= 62)) ? 1 : 0;
  endfunction

  function automatic string src_req(input logic [15:0] c);
    int ch = int'(c[5:0]);
    if (ch >= 60) return "R4";
    if (ch >= 4 && ch <= 31) return "R6";
    return "R5";
  endfunction

  task automatic gen_table(input int p_end, input int p_pause, input bit rsv);
    for (int i = 0; i < 64; i++) begin
      logic [15:0] w;
      w = 16'($urandom);
      if (!rsv) w[15:10] = '0;
      w[9] = (($urandom % 100) < p_pause);
      w[5:0] = (($urandom % 100) < p_end) ? 6'd63 : 6'($urandom % 63);
      tbl[i] = w;
    end
  endtask

  task automatic pulse_trigger();
    @(negedge clk) trigger = 1'b1;
    @(negedge clk) trigger = 1'b0;
  endtask

  task automatic serve(input int idx);
    int lat = 1 + int'($urandom % 4);
    bit inj = (($urandom % 3) == 0);
    logic [9:0] d = 10'($urandom);
    @(negedge clk);
    for (int k = 0; k < lat; k++) begin
      trigger = inj && (k == 0);
      @(negedge clk);
    end
    trigger = 1'b0;
    conv_done = 1'b1;
    conv_result = d;
    #1;
    chk(res_we == 1'b1, "R7", "res_we", int'(res_we), 1);
    chk(res_addr == 6'(idx), "R7", "res_addr", int'(res_addr), idx);
    chk(res_data == d, "R7", "res_data", int'(res_data), int'(d));
    if (inj) chk(st_active == 1'b1, "R11", "still active after trigger", int'(st_active), 1);
    @(negedge clk) conv_done = 1'b0;
  endtask

  task automatic run_queue();
    int idx = 0;
    bit fin = 0;
    pulse_trigger();
    while (!fin) begin
      int guard = 0;
      while (!conv_start && !st_paused && !st_complete && guard < 200) begin
        @(negedge clk);
        guard++;
      end
      if (guard >= 200) begin
        chk(0, "R2", "no progress", 0, 1);
        return;
      end
      if (conv_start) begin
        logic [15:0] c;
        c = tbl[idx];
        chk(idx < 64 && c[5:0] != 6'd63, "R9", "start on end marker", int'(c[5:0]), 0);
        chk(cmd_addr == 6'(idx), "R2", "cmd_addr order", int'(cmd_addr), idx);
        chk(conv_chan == c[5:0], "R1", "conv_chan", int'(conv_chan), int'(c[5:0]));
        chk(int'(conv_src) == exp_src(c, mux_mode), src_req(c), "conv_src", int'(conv_src), exp_src(c, mux_mode));
        chk(int'(conv_sample_cyc) == exp_cyc(c), "R3", "sample cycles", int'(conv_sample_cyc), exp_cyc(c));
        chk(int'(conv_bypass) == exp_byp(c), "R4", "bypass", int'(conv_bypass), exp_byp(c));
        serve(idx);
        idx++;
        if (idx == 64) begin
          chk(st_complete == 1'b1, "R10", "complete at table end", int'(st_complete), 1);
          fin = 1;
        end else if (c[9]) begin
          chk(st_paused == 1'b1, "R8", "paused", int'(st_paused), 1);
          repeat (3) @(negedge clk);
          chk(st_paused && !conv_start, "R8", "holds pause", int'(st_paused), 1);
          pulse_trigger();
        end
      end else if (st_complete) begin
        chk(idx < 64 && tbl[idx][5:0] == 6'd63, "R9", "complete at marker", idx, idx);
        fin = 1;
      end else begin
        chk(0, "R8", "unexpected pause", idx, -1);
        return;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL R2 watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0a1c));
    rst_n = 1'b0; mux_mode = 1'b1; trigger = 1'b0; conv_done = 1'b0; conv_result = '0;
    for (int i = 0; i < 64; i++) tbl[i] = 16'd63;
    repeat (3) @(negedge clk);
    chk(st_idle && !st_active && !st_paused && !st_complete, "R12", "reset idle", int'(st_idle), 1);
    chk(!conv_start && !res_we, "R12", "no start/write in reset", int'(conv_start), 0);
    chk(cmd_addr == 6'd0, "R12", "cmd_addr reset", int'(cmd_addr), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(st_idle == 1'b1, "R12", "idle after reset", int'(st_idle), 1);

    // R9: marker at index 0
    tbl[0] = 16'h003F;
    run_queue();

    // R10: full table, no marker, reserved bits random, pause at last entry
    gen_table(0, 0, 1);
    tbl[63][9] = 1'b1;
    mux_mode = 1'b0;
    run_queue();

    // R8/R10: pauses scattered, no marker, multiplexed
    gen_table(0, 15, 1);
    tbl[63][9] = 1'b1;
    mux_mode = 1'b1;
    run_queue();

    // R6: every mux-dependent channel in both modes
    for (int m = 0; m < 2; m++) begin
      for (int i = 0; i < 64; i++) tbl[i] = (i < 28) ? 16'(i + 4) | 16'(i % 4) << 6 : 16'h003F;
      mux_mode = m[0];
      run_queue();
    end

    // R4: internal sources with bypass bit clear
    tbl[0] = 16'h003C; tbl[1] = 16'h007D; tbl[2] = 16'h00BE; tbl[3] = 16'h003F;
    run_queue();

    // constrained random queues
    for (int q = 0; q < 25; q++) begin
      gen_table(4, 12, ($urandom % 2) == 1);
      mux_mode = ($urandom % 2) == 1;
      run_queue();
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule